// File: doc/BRIEF.md
# Serial Flash Status Register and Write-Protection Controller

This block is the device-side control logic of a serial NOR/NAND-style flash. It receives single-bit SPI traffic, in clock mode 0 or mode 3. It decodes the commands that read and write three byte-wide status and configuration registers. It also owns the write enable latch. Program and erase commands are not carried out here. They become one-cycle requests to an external array controller, which answers with a done pulse.

Two gates decide whether a write-type command has any effect. The first is a fixed window of clock cycles after reset is released. Inside it, write enable, status write, program and erase are all dropped, while reads work normally. The second is the write-protect input. A protection-enable bit in the protection register sets its reach. With the bit clear, a low `wp_n` guards only the protection register. With the bit set, a low `wp_n` makes the whole device read-only.

The SPI pins are sampled by the system clock through synchronisers. The serial clock must therefore run several times slower than `clk`.

Top module: `spi_flash_sr`

## Requirements
- R1: A read is opcode 0x0F, or its alias 0x05, followed by an address byte. From then on, each further byte shifts the addressed register out on `spi_miso`, MSB first. Addresses other than 0x0A, 0xB0 and 0xC0 read as 0x00.
- R2: After reset, the protection register (0x0A) reads 0x7C, the configuration register (0xB0) reads 0x00 and the status register (0xC0) reads 0x00. In the protection register, bit 1 is the protection-enable bit and bits 6:2 are the block-protect field. In the status register, bit 0 is busy and bit 1 is the write enable latch.
- R3: Opcode 0x1F, then an address byte, then a data byte writes that data to 0x0A or 0xB0. It needs no write enable latch and leaves the latch unchanged. A write to 0xC0 is ignored.
- R4: Opcode 0x06 sets the write enable latch.
- R5: Program (0x10) and erase (0xD8) raise a one-cycle `arr_prog_req` or `arr_erase_req` only when the latch is 1 and the device is not busy. Busy is then set.
- R6: An `arr_done` pulse while busy clears both busy and the write enable latch.
- R7: For INHIBIT_CYCLES clocks after reset is released, write enable, status write, program and erase are ignored. Reads still work.
- R8: With the protection-enable bit at 0 and `wp_n` low, writes to 0x0A are dropped. Such a blocked write does not clear the latch. Configuration writes, write enable and program still work.
- R9: With the protection-enable bit at 1 and `wp_n` low, write enable, status writes, program and erase are all rejected. Reads still work.
- R10: Raising chip select aborts any partly received command. While chip select is high, `spi_miso_oe` is low.
- R11: SPI mode 3 (clock idling high) works the same as mode 0. Input is sampled on rising edges and output changes on falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sclk | input | 1 | SPI serial clock |
| spi_mosi | input | 1 | SPI data into the device |
| spi_miso | output | 1 | SPI data out of the device |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (high = driven) |
| wp_n | input | 1 | Write-protect input, active low |
| arr_prog_req | output | 1 | One-cycle program request to the array |
| arr_erase_req | output | 1 | One-cycle erase request to the array |
| arr_done | input | 1 | Array reports the requested operation finished |

## Verification
The bench builds the block with INHIBIT_CYCLES = 2000 and SYNC_STAGES = 2. The short window lets the bench issue write enable, status write and program while the inhibit is still active, confirm that nothing changed, and then wait past the window within the same run. With two synchroniser stages and six clocks per SPI half-bit, every falling-edge output change settles before the bench samples it on the following rising edge. This holds in both clock polarities.

// File: rtl/spi_sr_pkg.sv
// Package: command codes, register addresses, field positions and the
// command-decoder state type shared by the status-register controller.
package spi_sr_pkg;
    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] OP_READ_SR     = 8'h0F;
    localparam logic [BYTE_W-1:0] OP_READ_SR_ALT = 8'h05;
    localparam logic [BYTE_W-1:0] OP_WRITE_SR    = 8'h1F;
    localparam logic [BYTE_W-1:0] OP_WR_ENABLE   = 8'h06;
    localparam logic [BYTE_W-1:0] OP_PROGRAM     = 8'h10;
    localparam logic [BYTE_W-1:0] OP_ERASE       = 8'hD8;

    localparam logic [BYTE_W-1:0] ADDR_PROT = 8'h0A;
    localparam logic [BYTE_W-1:0] ADDR_CONF = 8'hB0;
    localparam logic [BYTE_W-1:0] ADDR_STAT = 8'hC0;

    localparam logic [BYTE_W-1:0] PROT_RESET = 8'h7C;
    localparam int PROT_WPE_BIT = 1;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_RD_ADDR,
        ST_RD_DATA,
        ST_WR_ADDR,
        ST_WR_DATA,
        ST_SKIP
    } cmd_state_e;
endpackage

// File: rtl/spi_sr_frontend.sv
// Module: spi_sr_frontend
// Synchronises the SPI pins and the write-protect pin into the clk domain.
// It detects serial-clock edges while selected and assembles MSB-first bytes.
// Assumes the serial clock runs well below clk/(2*(SYNC_STAGES+2)).
module spi_sr_frontend
    import spi_sr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              mosi,
    input  logic              wp_n,
    output logic              sel,
    output logic              sclk_fall,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              wp_low
);
    localparam int NPINS = 4;
    localparam logic [NPINS-1:0] PIN_RESET = 4'b1001; // wp_n, mosi, sclk, cs_n

    logic [NPINS-1:0] stage [SYNC_STAGES];
    logic [NPINS-1:0] pins_s;
    logic             sclk_d;
    logic             sclk_rise;
    logic [BYTE_W-1:0] shreg;

    // Shift raw pins through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < SYNC_STAGES; k++) stage[k] <= PIN_RESET;
        end else begin
            stage[0] <= {wp_n, mosi, sclk, cs_n};
            for (int k = 1; k < SYNC_STAGES; k++) stage[k] <= stage[k-1];
        end
    end

    assign pins_s = stage[SYNC_STAGES-1];
    assign sel    = ~pins_s[0];
    assign wp_low = ~pins_s[3];

    // Remember the previous synchronised serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= pins_s[1];
    end

    assign sclk_rise = sel &  pins_s[1] & ~sclk_d;
    assign sclk_fall = sel & ~pins_s[1] &  sclk_d;

    // Collect data bits on rising edges and flag each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            bit_idx    <= '0;
            byte_valid <= 1'b0;
            shreg      <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (sclk_rise) begin
                shreg   <= {shreg[BYTE_W-2:0], pins_s[2]};
                bit_idx <= bit_idx + 1'b1;
                if (bit_idx == BIT_W'(BYTE_W-1)) byte_valid <= 1'b1;
            end
        end
    end

    assign byte_data = shreg;
endmodule

// File: rtl/spi_sr_cmd.sv
// Module: spi_sr_cmd
// Decodes command bytes into register accesses and single-cycle strobes.
// It drives the read data MSB first on serial-clock falling edges.
// Assumes the byte stream restarts whenever sel drops.
module spi_sr_cmd
    import spi_sr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              sclk_fall,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [BYTE_W-1:0] rd_value,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_strobe,
    output logic              wen_strobe,
    output logic              prog_strobe,
    output logic              erase_strobe,
    output logic              miso,
    output logic              miso_oe
);
    cmd_state_e state;

    // Step through opcode, address and data phases; restart on deselect.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            state        <= ST_OPCODE;
            wr_strobe    <= 1'b0;
            wen_strobe   <= 1'b0;
            prog_strobe  <= 1'b0;
            erase_strobe <= 1'b0;
            if (!rst_n) begin
                reg_addr <= '0;
                wr_data  <= '0;
            end
        end else begin
            wr_strobe    <= 1'b0;
            wen_strobe   <= 1'b0;
            prog_strobe  <= 1'b0;
            erase_strobe <= 1'b0;
            if (byte_valid) begin
                unique case (state)
                    ST_OPCODE: begin
                        state <= ST_SKIP;
                        if (byte_data == OP_READ_SR || byte_data == OP_READ_SR_ALT)
                            state <= ST_RD_ADDR;
                        else if (byte_data == OP_WRITE_SR)
                            state <= ST_WR_ADDR;
                        wen_strobe   <= (byte_data == OP_WR_ENABLE);
                        prog_strobe  <= (byte_data == OP_PROGRAM);
                        erase_strobe <= (byte_data == OP_ERASE);
                    end
                    ST_RD_ADDR: begin
                        reg_addr <= byte_data;
                        state    <= ST_RD_DATA;
                    end
                    ST_WR_ADDR: begin
                        reg_addr <= byte_data;
                        state    <= ST_WR_DATA;
                    end
                    ST_WR_DATA: begin
                        wr_data   <= byte_data;
                        wr_strobe <= 1'b1;
                        state     <= ST_SKIP;
                    end
                    default: state <= state;
                endcase
            end
        end
    end

    // Present the next read bit after each falling serial-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel)
            miso <= 1'b0;
        else if (sclk_fall && state == ST_RD_DATA)
            miso <= rd_value[BIT_W'(BYTE_W-1) - bit_idx];
    end

    assign miso_oe = sel && (state == ST_RD_DATA);
endmodule

// File: rtl/spi_sr_regs.sv
// Module: spi_sr_regs
// Holds the protection and configuration registers, the write enable latch
// and the busy flag. It times the post-reset inhibit window and applies the
// write-protect rules to every write-type strobe.
// Assumes the strobes are single-cycle pulses.
module spi_sr_regs
    import spi_sr_pkg::*;
#(
    parameter int INHIBIT_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_low,
    input  logic [BYTE_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_strobe,
    input  logic              wen_strobe,
    input  logic              prog_strobe,
    input  logic              erase_strobe,
    input  logic              arr_done,
    output logic [BYTE_W-1:0] rd_value,
    output logic              prog_req,
    output logic              erase_req,
    output logic              wel,
    output logic              busy,
    output logic              inhibit,
    output logic              dev_locked
);
    localparam int CNT_W = $clog2(INHIBIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(INHIBIT_CYCLES);

    logic [CNT_W-1:0]  inh_cnt;
    logic [BYTE_W-1:0] prot_q;
    logic [BYTE_W-1:0] conf_q;
    logic              write_ok;

    // Count out the post-reset inhibit window, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                inh_cnt <= '0;
        else if (inh_cnt != CNT_END) inh_cnt <= inh_cnt + 1'b1;
    end

    assign inhibit    = (inh_cnt != CNT_END);
    assign dev_locked = prot_q[PROT_WPE_BIT] & wp_low;
    assign write_ok   = ~inhibit & ~dev_locked;

    // Apply status writes that pass the inhibit and protect checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= PROT_RESET;
            conf_q <= '0;
        end else if (wr_strobe && write_ok) begin
            if (reg_addr == ADDR_PROT && !wp_low) prot_q <= wr_data;
            if (reg_addr == ADDR_CONF)            conf_q <= wr_data;
        end
    end

    // Track the write enable latch, busy flag and array requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel       <= 1'b0;
            busy      <= 1'b0;
            prog_req  <= 1'b0;
            erase_req <= 1'b0;
        end else begin
            prog_req  <= 1'b0;
            erase_req <= 1'b0;
            if (wen_strobe && write_ok) wel <= 1'b1;
            if ((prog_strobe || erase_strobe) && wel && !busy && write_ok) begin
                prog_req  <= prog_strobe;
                erase_req <= erase_strobe;
                busy      <= 1'b1;
            end
            if (arr_done && busy) begin
                busy <= 1'b0;
                wel  <= 1'b0;
            end
        end
    end

    // Select the register addressed by the current read.
    always_comb begin
        unique case (reg_addr)
            ADDR_PROT: rd_value = prot_q;
            ADDR_CONF: rd_value = conf_q;
            ADDR_STAT: rd_value = {{(BYTE_W-2){1'b0}}, wel, busy};
            default:   rd_value = '0;
        endcase
    end
endmodule

// File: rtl/spi_flash_sr.sv
// Module: spi_flash_sr (top)
// Device-side status-register and write-protection controller of a serial
// flash. It connects the pin front end, the command decoder and the
// register/protection bank. Program and erase leave as request pulses.
module spi_flash_sr
    import spi_sr_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int INHIBIT_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sclk,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe,
    input  logic wp_n,
    output logic arr_prog_req,
    output logic arr_erase_req,
    input  logic arr_done
);
    logic              sel, sclk_fall, byte_valid, wp_low;
    logic [BYTE_W-1:0] byte_data, reg_addr, wr_data, rd_value;
    logic [BIT_W-1:0]  bit_idx;
    logic              wr_strobe, wen_strobe, prog_strobe, erase_strobe;
    logic              wel, busy, inhibit, dev_locked;

    spi_sr_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk),
        .mosi(spi_mosi), .wp_n(wp_n), .sel(sel), .sclk_fall(sclk_fall),
        .byte_valid(byte_valid), .byte_data(byte_data), .bit_idx(bit_idx),
        .wp_low(wp_low)
    );

    spi_sr_cmd u_cmd (
        .clk(clk), .rst_n(rst_n), .sel(sel), .byte_valid(byte_valid),
        .byte_data(byte_data), .sclk_fall(sclk_fall), .bit_idx(bit_idx),
        .rd_value(rd_value), .reg_addr(reg_addr), .wr_data(wr_data),
        .wr_strobe(wr_strobe), .wen_strobe(wen_strobe),
        .prog_strobe(prog_strobe), .erase_strobe(erase_strobe),
        .miso(spi_miso), .miso_oe(spi_miso_oe)
    );

    spi_sr_regs #(.INHIBIT_CYCLES(INHIBIT_CYCLES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wp_low(wp_low), .reg_addr(reg_addr),
        .wr_data(wr_data), .wr_strobe(wr_strobe), .wen_strobe(wen_strobe),
        .prog_strobe(prog_strobe), .erase_strobe(erase_strobe),
        .arr_done(arr_done), .rd_value(rd_value), .prog_req(arr_prog_req),
        .erase_req(arr_erase_req), .wel(wel), .busy(busy),
        .inhibit(inhibit), .dev_locked(dev_locked)
    );
endmodule

// File: rtl/spi_flash_sr_chk.sv
// Module: spi_flash_sr_chk
// Property checker bound into spi_flash_sr. It watches the pins together
// with the latch, busy, inhibit and lock state of the register bank.
module spi_flash_sr_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic spi_miso_oe,
    input logic arr_prog_req,
    input logic arr_erase_req,
    input logic arr_done,
    input logic wel,
    input logic busy,
    input logic inhibit,
    input logic dev_locked
);
    logic [3:0] cs_hi_cnt;

    // Count consecutive sampled cycles with chip select high (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)             cs_hi_cnt <= '0;
        else if (!spi_cs_n)     cs_hi_cnt <= '0;
        else if (cs_hi_cnt != 4'hF) cs_hi_cnt <= cs_hi_cnt + 1'b1;
    end

    a_r10_deselect_tristate: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cs_hi_cnt) > SYNC_STAGES) |-> !spi_miso_oe);

    a_r5_req_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_prog_req || arr_erase_req) |-> (wel && busy));

    a_r5_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_prog_req && arr_erase_req));

    a_r5_busy_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (arr_prog_req || arr_erase_req));

    a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(arr_done && busy) |-> (!busy && !wel));

    a_r7_no_req_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inhibit) |-> !(arr_prog_req || arr_erase_req));

    a_r7_no_wel_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inhibit) && !$past(wel)) |-> !wel);

    a_r9_no_req_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dev_locked) |-> !(arr_prog_req || arr_erase_req));

    a_r9_no_wel_locked: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dev_locked) && !$past(wel)) |-> !wel);
endmodule

bind spi_flash_sr spi_flash_sr_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso_oe(spi_miso_oe),
    .arr_prog_req(arr_prog_req), .arr_erase_req(arr_erase_req),
    .arr_done(arr_done), .wel(wel), .busy(busy), .inhibit(inhibit),
    .dev_locked(dev_locked)
);

// File: tb/tb_spi_flash_sr.sv
// Directed bench for spi_flash_sr: one task per scenario, each checking
// its own results through the SPI pins and the array request outputs.
module tb_spi_flash_sr;
    localparam int INH = 2000;
    localparam int HP  = 6;   // clk cycles per SPI half bit

    logic clk = 1'b0, rst_n = 1'b0;
    logic spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0, wp_n = 1'b1;
    logic arr_done = 1'b0;
    logic spi_miso, spi_miso_oe, arr_prog_req, arr_erase_req;
    int   n_chk = 0, n_fail = 0, cyc = 0, prog_cnt = 0, erase_cnt = 0;
    logic [7:0] rx;

    always #4 clk = ~clk;

    spi_flash_sr #(.SYNC_STAGES(2), .INHIBIT_CYCLES(INH)) dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .wp_n(wp_n), .arr_prog_req(arr_prog_req),
        .arr_erase_req(arr_erase_req), .arr_done(arr_done)
    );

    // Bench-side cycle and array request counters.
    always @(posedge clk) begin
        if (rst_n) cyc <= cyc + 1;
        if (arr_prog_req)  prog_cnt  <= prog_cnt + 1;
        if (arr_erase_req) erase_cnt <= erase_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One SPI transaction of nbits bits from {b0,b1,b2}; returns last 8 bits read.
    task automatic spi_txn(input bit m3, input int nbits, input logic [7:0] b0,
                           input logic [7:0] b1, input logic [7:0] b2,
                           input bit keep_cs, output logic [7:0] rxo);
        logic [23:0] tx;
        logic [7:0]  sh;
        tx = {b0, b1, b2};
        sh = '0;
        spi_sclk = m3;
        ticks(1);
        spi_cs_n = 1'b0;
        ticks(HP);
        for (int i = 0; i < nbits; i++) begin
            spi_sclk = 1'b0;
            spi_mosi = tx[23-i];
            ticks(HP);
            sh = {sh[6:0], spi_miso};
            spi_sclk = 1'b1;
            ticks(HP);
        end
        rxo = sh;
        if (!keep_cs) begin
            spi_sclk = m3;
            ticks(HP);
            spi_cs_n = 1'b1;
            ticks(2 * HP);
        end
    endtask

    task automatic rd_chk(input string req, input bit m3, input logic [7:0] op,
                          input logic [7:0] addr, input int exp);
        logic [7:0] r;
        spi_txn(m3, 24, op, addr, 8'h00, 1'b0, r);
        chk(req, r, exp);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        spi_txn(1'b0, 8, op, 8'h00, 8'h00, 1'b0, r);
    endtask

    task automatic wr_sr(input logic [7:0] addr, input logic [7:0] d);
        logic [7:0] r;
        spi_txn(1'b0, 24, 8'h1F, addr, d, 1'b0, r);
    endtask

    task automatic pulse_done();
        arr_done = 1'b1;
        ticks(1);
        arr_done = 1'b0;
        ticks(4);
    endtask

    task automatic t_reset();
        chk("R10 oe after reset", spi_miso_oe, 0);
        chk("R5 no prog after reset", arr_prog_req, 0);
    endtask

    task automatic t_inhibit();
        int p0;
        p0 = prog_cnt;
        cmd1(8'h06);
        wr_sr(8'hB0, 8'h55);
        cmd1(8'h10);
        rd_chk("R7 WEL stays 0 in window", 1'b0, 8'h0F, 8'hC0, 8'h00);
        rd_chk("R7 conf write ignored", 1'b0, 8'h0F, 8'hB0, 8'h00);
        chk("R7 no program in window", prog_cnt - p0, 0);
        rd_chk("R2 prot reset value", 1'b0, 8'h0F, 8'h0A, 8'h7C);
        while (cyc < INH + 20) ticks(1);
    endtask

    task automatic t_reads_writes();
        rd_chk("R1 alias read prot", 1'b0, 8'h05, 8'h0A, 8'h7C);
        rd_chk("R1 unknown addr", 1'b0, 8'h0F, 8'h33, 8'h00);
        rd_chk("R2 conf reset", 1'b0, 8'h0F, 8'hB0, 8'h00);
        wr_sr(8'hB0, 8'hA5);
        rd_chk("R3 conf write", 1'b0, 8'h0F, 8'hB0, 8'hA5);
        rd_chk("R11 mode3 read", 1'b1, 8'h0F, 8'hB0, 8'hA5);
        begin
            logic [7:0] r;
            spi_txn(1'b1, 24, 8'h1F, 8'hB0, 8'h3C, 1'b0, r);
        end
        rd_chk("R11 mode3 write", 1'b0, 8'h05, 8'hB0, 8'h3C);
        wr_sr(8'hC0, 8'hFF);
        rd_chk("R3 stat write ignored", 1'b0, 8'h0F, 8'hC0, 8'h00);
    endtask

    task automatic t_program_erase();
        int p0, e0;
        p0 = prog_cnt; e0 = erase_cnt;
        cmd1(8'hD8);
        chk("R5 erase without WEL", erase_cnt - e0, 0);
        cmd1(8'h06);
        rd_chk("R4 WEL set", 1'b0, 8'h0F, 8'hC0, 8'h02);
        wr_sr(8'hB0, 8'h11);
        rd_chk("R3 write keeps WEL", 1'b0, 8'h0F, 8'hC0, 8'h02);
        cmd1(8'h10);
        chk("R5 program request", prog_cnt - p0, 1);
        rd_chk("R5 busy and WEL", 1'b0, 8'h0F, 8'hC0, 8'h03);
        cmd1(8'h10);
        chk("R5 no request while busy", prog_cnt - p0, 1);
        pulse_done();
        rd_chk("R6 done clears busy/WEL", 1'b0, 8'h0F, 8'hC0, 8'h00);
        cmd1(8'h06);
        cmd1(8'hD8);
        chk("R5 erase request", erase_cnt - e0, 1);
        pulse_done();
        rd_chk("R6 cleared after erase", 1'b0, 8'h0F, 8'hC0, 8'h00);
    endtask

    task automatic t_wp_soft();
        int p0;
        p0 = prog_cnt;
        wp_n = 1'b0;
        cmd1(8'h06);
        wr_sr(8'h0A, 8'h00);
        rd_chk("R8 prot write blocked", 1'b0, 8'h0F, 8'h0A, 8'h7C);
        rd_chk("R8 blocked write keeps WEL", 1'b0, 8'h0F, 8'hC0, 8'h02);
        wr_sr(8'hB0, 8'h77);
        rd_chk("R8 conf write allowed", 1'b0, 8'h0F, 8'hB0, 8'h77);
        cmd1(8'h10);
        chk("R8 program allowed", prog_cnt - p0, 1);
        pulse_done();
        wp_n = 1'b1;
        ticks(4);
    endtask

    task automatic t_wp_hard();
        int e0;
        e0 = erase_cnt;
        wr_sr(8'h0A, 8'h02);
        rd_chk("R3 prot write", 1'b0, 8'h0F, 8'h0A, 8'h02);
        wp_n = 1'b0;
        ticks(4);
        cmd1(8'h06);
        rd_chk("R9 WEN rejected", 1'b0, 8'h0F, 8'hC0, 8'h00);
        wr_sr(8'hB0, 8'h99);
        rd_chk("R9 conf write rejected", 1'b0, 8'h0F, 8'hB0, 8'h77);
        wp_n = 1'b1;
        ticks(4);
        cmd1(8'h06);
        wp_n = 1'b0;
        ticks(4);
        cmd1(8'hD8);
        chk("R9 erase rejected", erase_cnt - e0, 0);
        wp_n = 1'b1;
        ticks(4);
        cmd1(8'hD8);
        chk("R9 erase after release", erase_cnt - e0, 1);
        pulse_done();
        wr_sr(8'h0A, 8'h7C);
    endtask

    task automatic t_abort();
        logic [7:0] r;
        spi_txn(1'b0, 20, 8'h1F, 8'hB0, 8'hFF, 1'b0, r);
        rd_chk("R10 partial write aborted", 1'b0, 8'h0F, 8'hB0, 8'h77);
        spi_txn(1'b0, 20, 8'h0F, 8'hB0, 8'h00, 1'b1, r);
        chk("R10 oe during read", spi_miso_oe, 1);
        spi_sclk = 1'b0;
        ticks(HP);
        spi_cs_n = 1'b1;
        ticks(2 * HP);
        chk("R10 oe after deselect", spi_miso_oe, 0);
        rd_chk("R10 next command decodes", 1'b0, 8'h0F, 8'h0A, 8'h7C);
    endtask

    initial begin
        ticks(10);
        rst_n = 1'b1;
        ticks(2);
        t_reset();
        t_inhibit();
        t_reads_writes();
        t_program_erase();
        t_wp_soft();
        t_wp_hard();
        t_abort();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule